// File: doc/BRIEF.md
# Centralized Scoreboard Hazard Controller

This block is the central hazard bookkeeping for a single-issue pipeline with four functional units: integer/load (unit 0), floating-point add (unit 1), floating-point multiply (unit 2) and floating-point divide (unit 3). It shares eight floating-point registers among them. A decoder presents one decoded instruction at a time: the target unit, a destination register and two source registers. The controller accepts the instruction only when the target unit is free and no pending instruction still has to write the same destination. Each unit holds at most one instruction. For every unit the controller records its destination, its two sources, which unit will produce each source, and whether each source is ready and not yet read.

Each cycle the controller grants a read-operands step to every unit whose two sources are both ready. There is no forwarding: a consumer reads only in the cycle after its producer writes. A unit then executes until its done strobe arrives. It may write its result only when no other unit still has to read the old value of the register it is about to overwrite. At most one write is granted per cycle, and the lowest unit index wins. A write frees the unit and wakes every unit that was waiting for it. Issue stays in program order because the decoder holds an instruction until it is accepted. Execution and completion can happen out of program order.

Top module: `scoreboard_ctrl`

## Requirements
- R1: After reset no unit is busy, `rd_grant` and `wb_grant` are 0, and `in_ready` is 0 while `in_valid` is 0. An instruction presented to an idle unit with a free destination is accepted (`in_ready`=1 in the same cycle).
- R2: An instruction whose unit (`in_unit`: 0 integer, 1 add, 2 multiply, 3 divide) is busy is not accepted. A unit stays busy from the edge where its instruction is accepted through the cycle in which its `wb_grant` bit is high.
- R3: An instruction is not accepted while any accepted, not yet written instruction has the same destination register. It is accepted in the cycle after that writer's `wb_grant`.
- R4: A unit whose sources have no pending writer gets `rd_grant` in the cycle after its acceptance. A source with a pending writer holds `rd_grant` low until the cycle after that writer's `wb_grant`.
- R5: `rd_grant` is high for one cycle per instruction. A `fu_done` bit is ignored unless its unit has read operands and not yet finished execution.
- R6: A unit whose `fu_done` bit is high in the cycle after its read (or later) requests write-back from the next cycle on. It gets `wb_grant` then if no hazard of R7 or R8 blocks it.
- R7: A unit is denied write-back while another unit holds, as either source, the register the unit writes and has not yet read it. The write is granted in the cycle after that reader's `rd_grant`. Such a pending read never stalls issue.
- R8: At most one `wb_grant` bit is high per cycle. Among eligible units the lowest index is granted, and the others wait.
- R9: A unit can accept a new instruction in the cycle right after its `wb_grant`.
- R10: A later-accepted instruction with a shorter execution may write before an earlier-accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_unit | input | 2 | Target functional unit index |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| in_ready | output | 1 | Instruction accepted this cycle |
| fu_done | input | 4 | Per-unit execution-complete strobe |
| rd_grant | output | 4 | Per-unit read-operands grant |
| wb_grant | output | 4 | Per-unit write-result grant |

## Verification
A wrong producer tag or ready flag shows up at the read port. A consumer reads too early, with `rd_grant` in the cycle its producer writes or before it, or it never reads at all. The bench checks `rd_grant` in the exact cycle around each producer write. A wrong register result entry shows up on the very next presentation of a conflicting destination, because `in_ready` is combinational. A missed operand-pending flag lets a write-back through one cycle early, while a reader still holds the old value. The anti-dependence scenario watches `wb_grant` in every cycle from the done strobe to the grant to catch that.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_WRITE = 2'd3
    } stage_e;

endpackage

// File: rtl/sb_issue_check.sv
module sb_issue_check #(
    parameter int NUM_FU  = 4,
    parameter int NUM_REG = 8
) (
    input  logic                                          in_valid,
    input  logic [$clog2(NUM_FU)-1:0]                     in_unit,
    input  logic [$clog2(NUM_REG)-1:0]                    in_dst,
    input  logic [NUM_FU-1:0]                             busy_vec,
    input  logic [NUM_REG-1:0][$clog2(NUM_FU+1)-1:0]      res_tags,
    output logic                                          issue_ok
);
    localparam int FU_W = $clog2(NUM_FU + 1);
    localparam logic [FU_W-1:0] TAG_NONE = FU_W'(NUM_FU);

    logic unit_free;
    logic dst_free;

    always_comb begin
        unit_free = !busy_vec[in_unit];
        dst_free  = (res_tags[in_dst] == TAG_NONE);
        issue_ok  = in_valid && unit_free && dst_free;
    end
endmodule

// File: rtl/sb_war_check.sv
module sb_war_check #(
    parameter int NUM_FU = 4,
    parameter int REG_W  = 3
) (
    input  logic [NUM_FU-1:0]            busy_vec,
    input  logic [NUM_FU-1:0][REG_W-1:0] fi_vec,
    input  logic [NUM_FU-1:0][REG_W-1:0] fj_vec,
    input  logic [NUM_FU-1:0][REG_W-1:0] fk_vec,
    input  logic [NUM_FU-1:0]            rj_vec,
    input  logic [NUM_FU-1:0]            rk_vec,
    output logic [NUM_FU-1:0]            war_ok
);
    for (genvar w = 0; w < NUM_FU; w++) begin : g_writer
        logic [NUM_FU-1:0] blockers;
        for (genvar f = 0; f < NUM_FU; f++) begin : g_reader
            if (f == w) begin : g_self
                assign blockers[f] = 1'b0;
            end else begin : g_other
                assign blockers[f] = busy_vec[f] &&
                    ((fj_vec[f] == fi_vec[w] && rj_vec[f]) ||
                     (fk_vec[f] == fi_vec[w] && rk_vec[f]));
            end
        end
        assign war_ok[w] = ~|blockers;
    end
endmodule

// File: rtl/sb_prio_pick.sv
module sb_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
    import sb_pkg::*;
#(
    parameter int NUM_FU  = 4,
    parameter int NUM_REG = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [$clog2(NUM_FU)-1:0]     in_unit,
    input  logic [$clog2(NUM_REG)-1:0]    in_dst,
    input  logic [$clog2(NUM_REG)-1:0]    in_src1,
    input  logic [$clog2(NUM_REG)-1:0]    in_src2,
    output logic                          in_ready,
    input  logic [NUM_FU-1:0]             fu_done,
    output logic [NUM_FU-1:0]             rd_grant,
    output logic [NUM_FU-1:0]             wb_grant
);
    localparam int FU_W  = $clog2(NUM_FU + 1);
    localparam int REG_W = $clog2(NUM_REG);
    localparam logic [FU_W-1:0] TAG_NONE = FU_W'(NUM_FU);

    typedef struct packed {
        logic             busy;
        stage_e           stage;
        logic [REG_W-1:0] fi;
        logic [REG_W-1:0] fj;
        logic [REG_W-1:0] fk;
        logic [FU_W-1:0]  qj;
        logic [FU_W-1:0]  qk;
        logic             rj;
        logic             rk;
    } fu_ent_t;

    typedef struct packed {
        fu_ent_t [NUM_FU-1:0]            fu;
        logic [NUM_REG-1:0][FU_W-1:0]    res;
    } sb_state_t;

    sb_state_t st_d, st_q;

    logic [NUM_FU-1:0]            busy_vec;
    logic [NUM_FU-1:0][REG_W-1:0] fi_vec, fj_vec, fk_vec;
    logic [NUM_FU-1:0]            rj_vec, rk_vec;
    logic [NUM_FU-1:0]            war_ok;
    logic [NUM_FU-1:0]            wb_req;
    logic [FU_W-1:0]              wb_tag;
    logic [FU_W-1:0]              tag_j, tag_k;

    // flatten per-unit fields for the helper blocks
    for (genvar u = 0; u < NUM_FU; u++) begin : g_flat
        assign busy_vec[u] = st_q.fu[u].busy;
        assign fi_vec[u]   = st_q.fu[u].fi;
        assign fj_vec[u]   = st_q.fu[u].fj;
        assign fk_vec[u]   = st_q.fu[u].fk;
        assign rj_vec[u]   = st_q.fu[u].rj;
        assign rk_vec[u]   = st_q.fu[u].rk;
        assign rd_grant[u] = (st_q.fu[u].stage == ST_READ) &&
                             st_q.fu[u].rj && st_q.fu[u].rk;
        assign wb_req[u]   = (st_q.fu[u].stage == ST_WRITE) && war_ok[u];
    end

    sb_issue_check #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) i_issue (
        .in_valid (in_valid),
        .in_unit  (in_unit),
        .in_dst   (in_dst),
        .busy_vec (busy_vec),
        .res_tags (st_q.res),
        .issue_ok (in_ready)
    );

    sb_war_check #(.NUM_FU(NUM_FU), .REG_W(REG_W)) i_war (
        .busy_vec (busy_vec),
        .fi_vec   (fi_vec),
        .fj_vec   (fj_vec),
        .fk_vec   (fk_vec),
        .rj_vec   (rj_vec),
        .rk_vec   (rk_vec),
        .war_ok   (war_ok)
    );

    sb_prio_pick #(.N(NUM_FU)) i_wb_pick (
        .req (wb_req),
        .gnt (wb_grant)
    );

    // tag of the unit writing this cycle, NONE if nobody writes
    always_comb begin
        wb_tag = TAG_NONE;
        for (int u = 0; u < NUM_FU; u++) begin
            if (wb_grant[u]) wb_tag = FU_W'(u);
        end
    end

    // producer tags for the instruction being issued; a producer that
    // writes in this very cycle no longer counts as pending
    always_comb begin
        tag_j = st_q.res[in_src1];
        tag_k = st_q.res[in_src2];
        if (tag_j == wb_tag) tag_j = TAG_NONE;
        if (tag_k == wb_tag) tag_k = TAG_NONE;
    end

    always_comb begin
        st_d = st_q;
        for (int u = 0; u < NUM_FU; u++) begin
            if (rd_grant[u]) begin
                st_d.fu[u].rj    = 1'b0;
                st_d.fu[u].rk    = 1'b0;
                st_d.fu[u].stage = ST_EXEC;
            end
            if (st_q.fu[u].stage == ST_EXEC && fu_done[u]) begin
                st_d.fu[u].stage = ST_WRITE;
            end
            if (wb_grant[u]) begin
                st_d.fu[u].busy  = 1'b0;
                st_d.fu[u].stage = ST_IDLE;
                st_d.res[st_q.fu[u].fi] = TAG_NONE;
            end
        end
        // wake consumers of the writer
        if (wb_tag != TAG_NONE) begin
            for (int f = 0; f < NUM_FU; f++) begin
                if (st_q.fu[f].qj == wb_tag) begin
                    st_d.fu[f].rj = 1'b1;
                    st_d.fu[f].qj = TAG_NONE;
                end
                if (st_q.fu[f].qk == wb_tag) begin
                    st_d.fu[f].rk = 1'b1;
                    st_d.fu[f].qk = TAG_NONE;
                end
            end
        end
        // issue
        if (in_ready) begin
            st_d.fu[in_unit].busy  = 1'b1;
            st_d.fu[in_unit].stage = ST_READ;
            st_d.fu[in_unit].fi    = in_dst;
            st_d.fu[in_unit].fj    = in_src1;
            st_d.fu[in_unit].fk    = in_src2;
            st_d.fu[in_unit].qj    = tag_j;
            st_d.fu[in_unit].qk    = tag_k;
            st_d.fu[in_unit].rj    = (tag_j == TAG_NONE);
            st_d.fu[in_unit].rk    = (tag_k == TAG_NONE);
            st_d.res[in_dst]       = FU_W'(in_unit);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int u = 0; u < NUM_FU; u++) begin
                st_q.fu[u].qj <= TAG_NONE;
                st_q.fu[u].qk <= TAG_NONE;
            end
            for (int r = 0; r < NUM_REG; r++) begin
                st_q.res[r] <= TAG_NONE;
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NUM_FU  = 4,
    parameter int NUM_REG = 8
) (
    input logic                                       clk,
    input logic                                       rst_n,
    input logic                                       in_valid,
    input logic [$clog2(NUM_FU)-1:0]                  in_unit,
    input logic                                       in_ready,
    input logic [NUM_FU-1:0]                          rd_grant,
    input logic [NUM_FU-1:0]                          wb_grant,
    input logic [NUM_FU-1:0]                          busy_vec,
    input logic [NUM_FU-1:0][$clog2(NUM_REG)-1:0]     fi_vec
);
    localparam int CW = $clog2(NUM_FU + 1);

    // R8
    wb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant));

    // R2
    issue_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy_vec[$past(in_unit)]);

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        // R5
        rd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[u] |=> !rd_grant[u]);
        // R9
        wb_frees_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[u] |=> !busy_vec[u]);
        // R4
        rd_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[u] |-> busy_vec[u]);
    end

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        logic [CW-1:0] writers;
        always_comb begin
            writers = '0;
            for (int u = 0; u < NUM_FU; u++) begin
                if (busy_vec[u] && fi_vec[u] == ($clog2(NUM_REG))'(r))
                    writers = writers + CW'(1);
            end
        end
        // R3
        single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
            writers <= CW'(1));
    end
endmodule

bind scoreboard_ctrl sb_checker #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) i_sb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_unit  (in_unit),
    .in_ready (in_ready),
    .rd_grant (rd_grant),
    .wb_grant (wb_grant),
    .busy_vec (busy_vec),
    .fi_vec   (fi_vec)
);

// File: tb/test_scoreboard_ctrl.sv
module test_scoreboard_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [1:0] in_unit;
    logic [2:0] in_dst, in_src1, in_src2;
    logic       in_ready;
    logic [3:0] fu_done, rd_grant, wb_grant;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scoreboard_ctrl i_scoreboard_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_unit  (in_unit),
        .in_dst   (in_dst),
        .in_src1  (in_src1),
        .in_src2  (in_src2),
        .in_ready (in_ready),
        .fu_done  (fu_done),
        .rd_grant (rd_grant),
        .wb_grant (wb_grant)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        fu_done  = '0;
    endtask

    task automatic present(input int u, input int d, input int a, input int b);
        in_valid = 1'b1;
        in_unit  = 2'(u);
        in_dst   = 3'(d);
        in_src1  = 3'(a);
        in_src2  = 3'(b);
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk4(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        #1;
        chk4("R1 rd_grant after reset", rd_grant, 4'b0000);
        chk4("R1 wb_grant after reset", wb_grant, 4'b0000);
        chk1("R1 in_ready without valid", in_ready, 1'b0);
    endtask

    task automatic t_independent();
        present(1, 1, 2, 3); #1;
        chk1("R1 accept into idle unit", in_ready, 1'b1);
        tick();
        fu_done = 4'b0100; #1;
        chk4("R4 read next cycle", rd_grant, 4'b0010);
        tick();
        fu_done = 4'b0010; #1;
        chk4("R5 single read", rd_grant, 4'b0000);
        tick(); #1;
        chk4("R6 write after done", wb_grant, 4'b0010);
        tick(); #1;
        chk4("R5 idle unit done ignored", wb_grant, 4'b0000);
        tick();
    endtask

    task automatic t_raw();
        present(2, 4, 1, 1); #1;
        chk1("R1 accept mul", in_ready, 1'b1);
        tick();
        present(1, 5, 4, 2); #1;
        chk1("R4 consumer accepted", in_ready, 1'b1);
        chk4("R4 producer reads", rd_grant, 4'b0100);
        tick();
        fu_done = 4'b0010; #1;
        chk4("R4 consumer waits", rd_grant, 4'b0000);
        tick(); #1;
        chk4("R4 consumer still waits", rd_grant, 4'b0000);
        tick();
        fu_done = 4'b0100; #1;
        chk4("R6 no write before done", wb_grant, 4'b0000);
        tick(); #1;
        chk4("R6 producer writes", wb_grant, 4'b0100);
        chk4("R4 no forwarding", rd_grant, 4'b0000);
        tick(); #1;
        chk4("R4 read after producer write", rd_grant, 4'b0010);
        tick(); #1;
        chk4("R5 early done ignored", wb_grant, 4'b0000);
        fu_done = 4'b0010;
        tick(); #1;
        chk4("R6 consumer writes", wb_grant, 4'b0010);
        tick();
    endtask

    task automatic t_structural();
        present(1, 1, 2, 3); #1;
        chk1("R1 accept add", in_ready, 1'b1);
        tick();
        present(1, 6, 2, 3); #1;
        chk1("R2 unit busy stall", in_ready, 1'b0);
        tick();
        present(1, 6, 2, 3); fu_done = 4'b0010; #1;
        chk1("R2 busy in exec", in_ready, 1'b0);
        tick();
        present(1, 6, 2, 3); #1;
        chk4("R2 write cycle", wb_grant, 4'b0010);
        chk1("R2 busy through write", in_ready, 1'b0);
        tick();
        present(1, 6, 2, 3); #1;
        chk1("R9 reuse after write", in_ready, 1'b1);
        tick(); #1;
        chk4("R9 second add reads", rd_grant, 4'b0010);
        tick();
        fu_done = 4'b0010;
        tick(); #1;
        chk4("R9 second add writes", wb_grant, 4'b0010);
        tick();
    endtask

    task automatic t_waw();
        present(3, 2, 1, 1); #1;
        chk1("R1 accept div", in_ready, 1'b1);
        tick();
        present(1, 2, 3, 3); #1;
        chk1("R3 same destination stall", in_ready, 1'b0);
        tick();
        present(1, 2, 3, 3); fu_done = 4'b1000; #1;
        chk1("R3 stall during exec", in_ready, 1'b0);
        tick();
        present(1, 2, 3, 3); #1;
        chk4("R3 div writes", wb_grant, 4'b1000);
        chk1("R3 stall in write cycle", in_ready, 1'b0);
        tick();
        present(1, 2, 3, 3); #1;
        chk1("R3 accept after write", in_ready, 1'b1);
        tick(); #1;
        chk4("R3 add reads", rd_grant, 4'b0010);
        tick();
        fu_done = 4'b0010;
        tick(); #1;
        chk4("R3 add writes", wb_grant, 4'b0010);
        tick();
    endtask

    task automatic t_war();
        present(2, 0, 1, 1); #1;
        chk1("R7 accept mul", in_ready, 1'b1);
        tick();
        present(3, 3, 0, 6); #1;
        chk1("R7 accept div", in_ready, 1'b1);
        tick();
        present(1, 6, 2, 2); #1;
        chk1("R7 anti-dependence does not stall issue", in_ready, 1'b1);
        chk4("R4 div waits on mul", rd_grant, 4'b0000);
        tick(); #1;
        chk4("R7 add reads", rd_grant, 4'b0010);
        tick();
        fu_done = 4'b0010;
        tick(); #1;
        chk4("R7 write held for reader", wb_grant, 4'b0000);
        tick();
        fu_done = 4'b0100; #1;
        chk4("R7 write still held", wb_grant, 4'b0000);
        tick(); #1;
        chk4("R7 mul writes meanwhile", wb_grant, 4'b0100);
        tick(); #1;
        chk4("R4 div reads after mul", rd_grant, 4'b1000);
        chk4("R7 held during read cycle", wb_grant, 4'b0000);
        tick(); #1;
        chk4("R7 granted after read", wb_grant, 4'b0010);
        tick();
        fu_done = 4'b1000;
        tick(); #1;
        chk4("R6 div writes", wb_grant, 4'b1000);
        tick();
    endtask

    task automatic t_priority();
        present(1, 2, 3, 3); #1;
        chk1("R10 accept add first", in_ready, 1'b1);
        tick();
        present(0, 1, 4, 4); #1;
        chk1("R10 accept int second", in_ready, 1'b1);
        tick(); #1;
        chk4("R10 int reads", rd_grant, 4'b0001);
        tick();
        fu_done = 4'b1011;
        tick(); #1;
        chk4("R8 lowest index first", wb_grant, 4'b0001);
        tick(); #1;
        chk4("R8 other waits one cycle", wb_grant, 4'b0010);
        tick(); #1;
        chk4("R5 idle div done ignored", wb_grant, 4'b0000);
        tick();
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_unit  = '0;
        in_dst   = '0;
        in_src1  = '0;
        in_src2  = '0;
        fu_done  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_independent();
        t_raw();
        t_structural();
        t_waw();
        t_war();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule